// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple register bus. A down-counter steps once per pulse of a slow counting-clock enable. When the counter expires, the block raises an interrupt and reloads itself from the load register. Software acknowledges the interrupt by writing the interrupt-clear register, which also restarts the count. If a second expiry arrives while the interrupt is still pending and the reset stage is enabled, the block drives an active-low system reset. That reset stays asserted until the block's own reset input is applied.

Register writes use a single cycle, with no wait states, and reads are combinational from the address. A key register guards all other writable state. The block comes out of reset locked. Writing the key value opens the other registers, and writing any other value to the key register closes them again. The timeout equals the load value divided by the rate of the counting enable, which is nominally 3 MHz.

Top module: `wdog_two_stage`

## Requirements
- R1: After `rstN` is released, the block reads as follows. The count and the load value are both 0xFFFFFFFF. Control is 0 and the counter is stopped. Raw and masked status are 0. Offset 0xC00 reads 1, meaning locked. `irqOut` is 0 and `sysRstN` is 1.
- R2: While control bit 0 is 0, the count at offset 0x004 does not change on counting pulses.
- R3: While control bit 0 is 1, each cycle with `tickEn` high lowers the count by one. Cycles without `tickEn` leave the count unchanged.
- R4: An expiry happens on a counting pulse that finds the count at 1 or at 0. On an expiry, raw status bit 0 at offset 0x010 sets and the count reloads from the load value. Starting from a reload with load value L ≥ 1, expiry falls on the L-th pulse.
- R5: An unlocked write of any data to offset 0x00C has two effects: it clears raw status and it reloads the count from the load value. If an expiry occurs in the same cycle, the clear wins.
- R6: Suppose an expiry happens while raw status is already 1 and control holds 0x3, where bit 0 is the counter enable and bit 1 is the reset enable. Then `sysRstN` goes low on the next edge. With bit 1 clear, later expiries leave `sysRstN` high and raw status stays 1.
- R7: Once `sysRstN` is low, it stays low until `rstN` is applied. Clearing the interrupt does not release it.
- R8: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and 0xC00 then reads 0. Writing any other value there locks it, and 0xC00 reads 1. While locked, writes to offsets 0x000, 0x008 and 0x00C are ignored.
- R9: Masked status bit 0 at offset 0x014 equals raw status AND control bit 0. `irqOut` equals masked status on every cycle.
- R10: An unlocked write to offset 0x000 sets the load value and reloads the count with that data in the same edge. Offset 0x004 is read-only.
- R11: Control at offset 0x008 reads back bits [1:0] as written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low asynchronous reset of the block |
| tickEn | input | 1 | One-cycle counting pulse (slow counting clock) |
| busWr | input | 1 | Register write strobe, single cycle |
| busAddr | input | 12 | Byte offset of the register accessed |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt, equal to masked status |
| sysRstN | output | 1 | Active-low system reset request, sticky |

## Verification
The assertions are checked on every cycle:
- the count stays still when no step, load or reload is requested;
- each step lowers the count by exactly one;
- a reload lands on the load value;
- a locked control write leaves control unchanged;
- raw status only rises after an expiry;
- the system reset falls only with status pending and the reset stage enabled, and it never comes back up by itself.

Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural model every clock. These include the expiry period in counting pulses, acknowledgement through the clear register, the two-expiry path to reset with and without the reset stage enabled, key handling, and the read-only count register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes from the register control into the counter datapath.
  typedef struct packed {
    logic wrLoad;   // new load value, also reloads the count
    logic reload;   // restart count from the current load value
    logic countEn;  // counter running
  } wdStrobe_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] LOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] loadVal,
  output logic              zeroEvt
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] loadQ;
  logic              stepReq;
  logic              atLast;

  assign stepReq = strobe.countEn && tickEn && !strobe.wrLoad && !strobe.reload;
  assign atLast  = (countQ <= ONE);
  assign zeroEvt = stepReq && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ <= LOAD_INIT;
    end else if (strobe.wrLoad) begin
      loadQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= LOAD_INIT;
    end else if (strobe.wrLoad) begin
      countQ <= wrData;
    end else if (strobe.reload) begin
      countQ <= loadQ;
    end else if (stepReq) begin
      countQ <= atLast ? loadQ : (countQ - ONE);
    end
  end

  assign countVal = countQ;
  assign loadVal  = loadQ;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!(strobe.countEn && tickEn) && !strobe.wrLoad && !strobe.reload) |=> $stable(countQ)); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && tickEn && !strobe.wrLoad && !strobe.reload && (countQ > ONE))
      |=> (countQ == $past(countQ) - ONE)); // R3

  AST_RELOAD_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && !strobe.wrLoad) |=> (countQ == $past(loadQ))); // R5

endmodule

// File: rtl/wdog_regctl.sv
module wdog_regctl
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              zeroEvt,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] loadVal,
  output wdStrobe_t         strobe,
  output logic              irqOut,
  output logic              sysRstN
);

  localparam logic [ADDR_W-1:0] OFS_LOAD  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFS_CLR   = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFS_RAW   = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] OFS_KEY   = ADDR_W'(12'hC00);

  logic       lockedQ;
  logic [1:0] ctrlQ;
  logic       risQ;
  logic       rstHitQ;
  logic       regWrOk;
  logic       misBit;

  assign regWrOk = busWr && !lockedQ;

  always_comb begin
    strobe.wrLoad  = regWrOk && (busAddr == OFS_LOAD);
    strobe.reload  = regWrOk && (busAddr == OFS_CLR);
    strobe.countEn = ctrlQ[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockedQ <= 1'b1;
    end else if (busWr && (busAddr == OFS_KEY)) begin
      lockedQ <= (busWdata != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= 2'b00;
    end else if (regWrOk && (busAddr == OFS_CTRL)) begin
      ctrlQ <= busWdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      risQ <= 1'b0;
    end else if (strobe.reload) begin
      risQ <= 1'b0;
    end else if (zeroEvt) begin
      risQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstHitQ <= 1'b0;
    end else if (zeroEvt && risQ && (ctrlQ == 2'b11)) begin
      rstHitQ <= 1'b1;
    end
  end

  assign misBit  = risQ && ctrlQ[0];
  assign irqOut  = misBit;
  assign sysRstN = !rstHitQ;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      OFS_LOAD:  busRdata = loadVal;
      OFS_COUNT: busRdata = countVal;
      OFS_CTRL:  busRdata = DATA_W'(ctrlQ);
      OFS_RAW:   busRdata = DATA_W'(risQ);
      OFS_MASK:  busRdata = DATA_W'(misBit);
      OFS_KEY:   busRdata = DATA_W'(lockedQ);
      default:   busRdata = '0;
    endcase
  end

  AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    (lockedQ && busWr && (busAddr == OFS_CTRL)) |=> $stable(ctrlQ)); // R8

  AST_RIS_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(risQ) |-> $past(zeroEvt)); // R4

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstN) |-> ($past(risQ) && $past(ctrlQ[1]) && $past(zeroEvt))); // R6

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !sysRstN |=> !sysRstN); // R7

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551,
  parameter logic [DATA_W-1:0] LOAD_INIT  = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              sysRstN
);

  wdStrobe_t         strobe;
  logic              zeroEvt;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] loadVal;

  wdog_regctl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_regctl (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .zeroEvt(zeroEvt), .countVal(countVal), .loadVal(loadVal),
    .strobe(strobe), .irqOut(irqOut), .sysRstN(sysRstN)
  );

  wdog_datapath #(
    .DATA_W(DATA_W), .LOAD_INIT(LOAD_INIT)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrData(busWdata), .tickEn(tickEn),
    .countVal(countVal), .loadVal(loadVal), .zeroEvt(zeroEvt)
  );

endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;

  localparam int CYC = 10;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = 12'hFF0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        sysRstN;

  int checks = 0;
  int errors = 0;
  bit autoTick = 1'b0;
  int divCnt = 0;

  // behavioural model state
  bit          mLocked;
  logic [31:0] mLoad, mCount;
  logic [1:0]  mCtrl;
  bit          mRis, mRst;

  always #(CYC/2) clk = ~clk;

  wdog_two_stage u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .sysRstN(sysRstN)
  );

  // counting pulse: one cycle in four while autoTick is set
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 4;
    tickEn = autoTick && (divCnt == 0);
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLocked = 1; mLoad = 32'hFFFF_FFFF; mCount = 32'hFFFF_FFFF;
      mCtrl = 0; mRis = 0; mRst = 0;
    end else begin
      bit wrOk, expire, oldRis;
      logic [1:0] oldCtrl;
      wrOk = busWr && !mLocked;
      expire = 0; oldRis = mRis; oldCtrl = mCtrl;
      if (wrOk && busAddr == 12'h000) begin
        mLoad = busWdata; mCount = busWdata;
      end else if (wrOk && busAddr == 12'h00C) begin
        mCount = mLoad;
      end else if (oldCtrl[0] && tickEn) begin
        if (mCount <= 1) begin expire = 1; mCount = mLoad; end
        else mCount = mCount - 1;
      end
      if (wrOk && busAddr == 12'h00C) mRis = 0;
      else if (expire) mRis = 1;
      if (expire && oldRis && oldCtrl == 2'b11) mRst = 1;
      if (wrOk && busAddr == 12'h008) mCtrl = busWdata[1:0];
      if (busWr && busAddr == 12'hC00) mLocked = (busWdata != KEY);
    end
  end

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a)
      12'h000: return mLoad;
      12'h004: return mCount;
      12'h008: return {30'b0, mCtrl};
      12'h010: return {31'b0, mRis};
      12'h014: return {31'b0, mRis & mCtrl[0]};
      12'hC00: return {31'b0, mLocked};
      default: return 32'h0;
    endcase
  endfunction

  // every-cycle comparison of the output pins (R9, R6, R7)
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (irqOut !== (mRis & mCtrl[0])) begin
        errors++;
        $display("FAIL R9 irqOut actual %0b expected %0b at %0t", irqOut, mRis & mCtrl[0], $time);
      end
      checks++;
      if (sysRstN !== !mRst) begin
        errors++;
        $display("FAIL R6/R7 sysRstN actual %0b expected %0b at %0t", sysRstN, !mRst, $time);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busAddr = 12'hFF0; busWdata = '0;
  endtask

  task automatic readChk(input logic [11:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    busAddr = a;
    #1;
    exp = modelRead(a);
    checks++;
    if (busRdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, busRdata, exp);
    end
    busAddr = 12'hFF0;
  endtask

  task automatic pinChk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CYC * 150000);
    errors++;
    $display("FAIL watchdog timeout of the bench");
    finishRun();
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    readChk(12'h000, "R1 load");
    readChk(12'h004, "R1 count");
    readChk(12'h008, "R1 ctrl");
    readChk(12'h010, "R1 raw");
    readChk(12'h014, "R1 masked");
    readChk(12'hC00, "R1 lock");
    pinChk(irqOut, 1'b0, "R1 irqOut");
    pinChk(sysRstN, 1'b1, "R1 sysRstN");
    readChk(12'h100, "R11 unmapped");

    // R8 locked writes ignored
    busWrite(12'h008, 32'h3);
    busWrite(12'h000, 32'h55);
    readChk(12'h008, "R8 ctrl locked");
    readChk(12'h000, "R8 load locked");

    // R8 unlock, R10 load and read-only count
    busWrite(12'hC00, KEY);
    readChk(12'hC00, "R8 unlocked");
    busWrite(12'h000, 32'd20);
    readChk(12'h004, "R10 count after load");
    busWrite(12'h004, 32'd5);
    readChk(12'h004, "R10 count read-only");

    // R2 stopped while disabled
    autoTick = 1'b1;
    waitCyc(50);
    readChk(12'h004, "R2 stopped");

    // R3/R4 running, expiry, R9 masked
    busWrite(12'h008, 32'h3);
    readChk(12'h008, "R11 ctrl readback");
    waitCyc(30);
    readChk(12'h004, "R3 decrement");
    waitCyc(60);
    readChk(12'h010, "R4 raw set");
    readChk(12'h014, "R9 masked set");
    pinChk(irqOut, 1'b1, "R9 irq high");

    // R5 acknowledge restarts
    busWrite(12'h00C, 32'h0);
    readChk(12'h010, "R5 raw cleared");
    readChk(12'h004, "R5 count reloaded");
    waitCyc(60);
    busWrite(12'h00C, 32'hDEAD);
    readChk(12'h010, "R5 clear any data");

    // R6 with reset stage off: two expiries, no reset
    busWrite(12'h008, 32'h1);
    waitCyc(200);
    readChk(12'h010, "R6 raw held");
    pinChk(sysRstN, 1'b1, "R6 no reset without bit1");

    // R9 masked off with ctrl 0
    busWrite(12'h008, 32'h0);
    readChk(12'h014, "R9 masked off");
    readChk(12'h010, "R9 raw still set");

    // R8 relock: clear ignored
    busWrite(12'hC00, 32'h0);
    readChk(12'hC00, "R8 relocked");
    busWrite(12'h00C, 32'h0);
    readChk(12'h010, "R8 clear ignored");

    // R6/R7 two-stage reset
    busWrite(12'hC00, KEY);
    busWrite(12'h00C, 32'h0);
    busWrite(12'h000, 32'd10);
    busWrite(12'h008, 32'h3);
    waitCyc(120);
    pinChk(sysRstN, 1'b0, "R6 reset asserted");
    busWrite(12'h00C, 32'h0);
    busWrite(12'h008, 32'h0);
    waitCyc(10);
    pinChk(sysRstN, 1'b0, "R7 reset sticky");

    doReset();
    pinChk(sysRstN, 1'b1, "R7 released by rstN");
    readChk(12'hC00, "R1 locked again");

    // R4 load of 1: expiry on each pulse
    busWrite(12'hC00, KEY);
    busWrite(12'h000, 32'd1);
    busWrite(12'h008, 32'h1);
    waitCyc(6);
    readChk(12'h010, "R4 load one");
    readChk(12'h004, "R4 count at one");
    autoTick = 1'b0;
    waitCyc(5);
    finishRun();
  end

endmodule